// File: doc/BRIEF.md
# SAR Converter Conversion Sequencer

This block is the digital half of a successive-approximation converter. Each conversion runs three ordered phases: a fixed precharge, an acquisition window whose length comes from the timing word, and a 16-step binary search. In the search the block drives a trial code towards the capacitor DAC and reads back a single comparator bit. The finished code is written into a result register that belongs to the selected input channel. A differential conversion is filed under its positive input. When the result for the monitored channel crosses a programmable threshold, a one-cycle interrupt pulse is raised.

Conversions start in one of three ways: a software start pulse for a single conversion, free-running back-to-back conversions paced by the period field, or rising edges on an external trigger pin. The timing word holds the acquisition length and the conversion period as two separate fields. If the period is too short to fit a whole conversion, it is stretched until the conversion fits. The analog array, the input multiplexer and the comparator itself sit outside this block.

Top module: `sar_seq`

## Requirements
- R1: After reset `busy`, `conv_strobe` and `irq` are low and every result register reads zero.
- R2: A start accepted at a clock edge raises `busy` for exactly 2 + A + 16 cycles. These are 2 precharge cycles, then A acquisition cycles, then 16 search cycles. A is `timing_cfg[25:16]`, and a value of 0 counts as 1. `busy` falls at the edge that writes the result.
- R3: `conv_strobe` is high for one cycle only: the first search cycle, which is busy cycle index 2 + A counting from 0.
- R4: The search tests one bit per cycle from bit 15 down to bit 0. A bit is kept when `cmp_in` is 1, meaning the input is at or above the trial level. With an ideal comparator the result equals the input code.
- R5: The result is stored in register `chan_sel` (word `data_flat[32*ch +: 32]`) in bits [27:12], with the MSB at bit 27 and all other bits zero. With `diff_en` = 1 the result still goes to register `chan_sel`, which is the positive input, and `mux_diff` is high during the conversion. No other register changes.
- R6: In mode 01 (single), a `sw_start` pulse starts one conversion. A `sw_start` that arrives while busy is ignored. In mode 00 (off), `sw_start` is ignored.
- R7: In mode 11 (external), each rising edge of `ext_trig` starts one conversion. A level held high does not start another one, and an edge that arrives while busy is ignored.
- R8: In mode 10 (continuous), conversions repeat, and successive `conv_strobe` pulses are `timing_cfg[9:0]` cycles apart.
- R9: In continuous mode, if `timing_cfg[9:0]` is less than 2 + A + 16, the strobe spacing is 2 + A + 16 instead.
- R10: When channel 4 is written, `irq` pulses for one cycle, together with the fall of `busy`, if `thr_above` = 1 and result > `thr_level`, or if `thr_above` = 0 and result < `thr_level`. There is no pulse on equality or on writes to other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 off, 01 single, 10 continuous, 11 external trigger |
| sw_start | input | 1 | Software start pulse (single mode) |
| ext_trig | input | 1 | External trigger pin, rising-edge active |
| chan_sel | input | 3 | Channel (positive input) to convert |
| diff_en | input | 1 | Differential conversion |
| timing_cfg | input | 32 | [25:16] acquisition cycles, [9:0] conversion period |
| cmp_in | input | 1 | Comparator: 1 when input is at or above trial level |
| thr_level | input | 16 | Threshold for the monitored channel |
| thr_above | input | 1 | 1: interrupt above threshold, 0: below |
| dac_trial | output | 16 | Trial code for the capacitor DAC (0 outside search) |
| conv_strobe | output | 1 | Start-of-conversion strobe |
| busy | output | 1 | Conversion in progress |
| mux_chan | output | 3 | Latched channel for the input multiplexer |
| mux_diff | output | 1 | Latched differential flag |
| data_flat | output | 256 | Eight 32-bit result registers, channel 0 in the low word |
| irq | output | 1 | Threshold interrupt pulse |

## Verification
The search is run on input codes at both rails, at mid-scale and at its neighbour 0x7FFF, and on alternating-bit and single-LSB codes. Together these show whether any single trial bit is mis-kept or mis-ordered. The same comparator model runs on several channels and in differential mode, which shows whether routing follows the positive input and whether other registers are left alone. Acquisition values of 0, 5 and 20 separate the phase-length arithmetic from the strobe position. In continuous mode, a long period, a period shorter than one conversion and a period with a short acquisition separate plain pacing from stretching. Threshold cases one code above, equal to and below the limit, plus a large value on a different channel, show whether the comparison is strict and whether it is bound to channel 4.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PRE  = 3'd1,
    PH_ACQ  = 3'd2,
    PH_CONV = 3'd3,
    PH_HOLD = 3'd4
  } phase_t;

  localparam logic [1:0] MODE_OFF = 2'b00;
  localparam logic [1:0] MODE_ONE = 2'b01;
  localparam logic [1:0] MODE_RUN = 2'b10;
  localparam logic [1:0] MODE_EXT = 2'b11;
endpackage

// File: rtl/sar_timing.sv
module sar_timing
  import sar_pkg::*;
#(
  parameter int PRE_CYC = 2,
  parameter int FLD_W   = 10,
  parameter int RES     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             sw_start_i,
  input  logic             ext_trig_i,
  input  logic [FLD_W-1:0] acq_i,
  input  logic [FLD_W-1:0] prd_i,
  input  logic             last_step_i,
  output logic             start_o,
  output logic             conv_o,
  output logic             strobe_o,
  output logic             busy_o,
  output logic             wr_o
);
  localparam int CNT_W = FLD_W + 2;
  localparam logic [CNT_W-1:0] PRE_LD = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] PRE_C  = CNT_W'(PRE_CYC);
  localparam logic [CNT_W-1:0] RES_C  = CNT_W'(RES);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  phase_t st_q, st_d;
  logic [CNT_W-1:0] ph_q, ph_d, per_q, per_d;
  logic [FLD_W-1:0] acq_q, prd_q;
  logic             ext_q, strobe_q;
  logic [CNT_W-1:0] acq_eff, min_tot, prd_ext, per_eff;
  logic             ext_rise, trig_ok, start_idle, restart, start;

  assign ext_rise   = ext_trig_i & ~ext_q;
  assign trig_ok    = ((mode_i == MODE_ONE) && sw_start_i) ||
                      ((mode_i == MODE_EXT) && ext_rise)   ||
                      (mode_i == MODE_RUN);
  assign start_idle = (st_q == PH_IDLE) && trig_ok;

  assign acq_eff = (acq_q == '0) ? ONE_C : {2'b00, acq_q};
  assign min_tot = PRE_C + acq_eff + RES_C;
  assign prd_ext = {2'b00, prd_q};
  assign per_eff = (prd_ext < min_tot) ? min_tot : prd_ext;

  assign restart = (mode_i == MODE_RUN) && (per_q == per_eff - ONE_C) &&
                   ((st_q == PH_HOLD) || ((st_q == PH_CONV) && last_step_i));
  assign start   = start_idle || restart;

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    if (ph_q != '0) ph_d = ph_q - ONE_C;
    case (st_q)
      PH_IDLE: if (start_idle) st_d = PH_PRE;
      PH_PRE: begin
        if (ph_q == '0) begin
          st_d = PH_ACQ;
          ph_d = acq_eff - ONE_C;
        end
      end
      PH_ACQ:  if (ph_q == '0) st_d = PH_CONV;
      PH_CONV: begin
        if (last_step_i) begin
          if (restart)                 st_d = PH_PRE;
          else if (mode_i == MODE_RUN) st_d = PH_HOLD;
          else                         st_d = PH_IDLE;
        end
      end
      PH_HOLD: begin
        if (restart)                 st_d = PH_PRE;
        else if (mode_i != MODE_RUN) st_d = PH_IDLE;
      end
      default: st_d = PH_IDLE;
    endcase
    if (start) ph_d = PRE_LD;
    if (start)                 per_d = '0;
    else if (st_q != PH_IDLE)  per_d = per_q + ONE_C;
    else                       per_d = per_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PH_IDLE;
      ph_q     <= '0;
      per_q    <= '0;
      ext_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      ph_q     <= ph_d;
      per_q    <= per_d;
      ext_q    <= ext_trig_i;
      strobe_q <= (st_q == PH_ACQ) && (ph_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acq_q <= '0;
      prd_q <= '0;
    end else if (start) begin
      acq_q <= acq_i;
      prd_q <= prd_i;
    end
  end

  assign start_o  = start;
  assign conv_o   = (st_q == PH_CONV);
  assign strobe_o = strobe_q;
  assign busy_o   = (st_q == PH_PRE) || (st_q == PH_ACQ) || (st_q == PH_CONV);
  assign wr_o     = (st_q == PH_CONV) && last_step_i;

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_o));

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int RES = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init_i,
  input  logic           active_i,
  input  logic           cmp_i,
  output logic [RES-1:0] trial_o,
  output logic [RES-1:0] result_o,
  output logic           last_o
);
  localparam logic [RES-1:0] TOP_BIT = {1'b1, {(RES-1){1'b0}}};

  logic [RES-1:0] mask_q, mask_d, acc_q, acc_d, probe;

  assign probe    = acc_q | mask_q;
  assign result_o = cmp_i ? probe : acc_q;
  assign trial_o  = active_i ? probe : '0;
  assign last_o   = mask_q[0];

  always_comb begin
    mask_d = mask_q;
    acc_d  = acc_q;
    if (init_i) begin
      mask_d = TOP_BIT;
      acc_d  = '0;
    end else if (active_i) begin
      mask_d = mask_q >> 1;
      acc_d  = result_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      acc_q  <= '0;
    end else begin
      mask_q <= mask_d;
      acc_q  <= acc_d;
    end
  end

  // R4
  mask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (mask_q != '0));
endmodule

// File: rtl/sar_results.sv
module sar_results #(
  parameter int NUM_CH  = 8,
  parameter int RES     = 16,
  parameter int DW      = 32,
  parameter int MSB_POS = 27,
  parameter int THR_CH  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_i,
  input  logic [$clog2(NUM_CH)-1:0] wr_ch_i,
  input  logic [RES-1:0]            value_i,
  input  logic [RES-1:0]            thr_i,
  input  logic                      thr_above_i,
  output logic [NUM_CH*DW-1:0]      data_o,
  output logic                      irq_o
);
  localparam int LSB_POS = MSB_POS - RES + 1;
  localparam int CH_W    = $clog2(NUM_CH);

  logic [DW-1:0] word;
  logic          hit, irq_q;

  assign word = DW'(value_i) << LSB_POS;
  assign hit  = wr_i && (wr_ch_i == CH_W'(THR_CH)) &&
                (thr_above_i ? (value_i > thr_i) : (value_i < thr_i));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
    logic [DW-1:0] reg_q;
    logic          en;
    assign en = wr_i && (wr_ch_i == CH_W'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  reg_q <= '0;
      else if (en) reg_q <= word;
    end
    assign data_o[c*DW +: DW] = reg_q;

    // R5
    untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && (wr_ch_i == CH_W'(c))) |=> $stable(data_o[c*DW +: DW]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= hit;
  end
  assign irq_o = irq_q;

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(wr_i));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int RES     = 16,
  parameter int DW      = 32,
  parameter int MSB_POS = 27,
  parameter int FLD_W   = 10,
  parameter int ACQ_LSB = 16,
  parameter int PRD_LSB = 0,
  parameter int PRE_CYC = 2,
  parameter int THR_CH  = 4,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic                 sw_start,
  input  logic                 ext_trig,
  input  logic [CH_W-1:0]      chan_sel,
  input  logic                 diff_en,
  input  logic [31:0]          timing_cfg,
  input  logic                 cmp_in,
  input  logic [RES-1:0]       thr_level,
  input  logic                 thr_above,
  output logic [RES-1:0]       dac_trial,
  output logic                 conv_strobe,
  output logic                 busy,
  output logic [CH_W-1:0]      mux_chan,
  output logic                 mux_diff,
  output logic [NUM_CH*DW-1:0] data_flat,
  output logic                 irq
);
  logic           start, conv, wr, last_step;
  logic [RES-1:0] result;
  logic [CH_W-1:0] ch_q;
  logic            diff_q;

  sar_timing #(.PRE_CYC(PRE_CYC), .FLD_W(FLD_W), .RES(RES)) u_timing (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode),
    .sw_start_i  (sw_start),
    .ext_trig_i  (ext_trig),
    .acq_i       (timing_cfg[ACQ_LSB +: FLD_W]),
    .prd_i       (timing_cfg[PRD_LSB +: FLD_W]),
    .last_step_i (last_step),
    .start_o     (start),
    .conv_o      (conv),
    .strobe_o    (conv_strobe),
    .busy_o      (busy),
    .wr_o        (wr)
  );

  sar_search #(.RES(RES)) u_search (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_i   (start),
    .active_i (conv),
    .cmp_i    (cmp_in),
    .trial_o  (dac_trial),
    .result_o (result),
    .last_o   (last_step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q   <= '0;
      diff_q <= 1'b0;
    end else if (start) begin
      ch_q   <= chan_sel;
      diff_q <= diff_en;
    end
  end
  assign mux_chan = ch_q;
  assign mux_diff = diff_q;

  sar_results #(
    .NUM_CH(NUM_CH), .RES(RES), .DW(DW), .MSB_POS(MSB_POS), .THR_CH(THR_CH)
  ) u_results (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (wr),
    .wr_ch_i     (ch_q),
    .value_i     (result),
    .thr_i       (thr_level),
    .thr_above_i (thr_above),
    .data_o      (data_flat),
    .irq_o       (irq)
  );

  // R3
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |-> busy);
endmodule

// File: tb/sar_seq_test.sv
module sar_seq_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode;
  logic         sw_start, ext_trig, diff_en, thr_above;
  logic [2:0]   chan_sel;
  logic [31:0]  timing_cfg;
  logic [15:0]  thr_level, vin;
  logic         cmp_in;
  logic [15:0]  dac_trial;
  logic         conv_strobe, busy, mux_diff, irq;
  logic [2:0]   mux_chan;
  logic [255:0] data_flat;

  int errs = 0;
  int checks = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  assign cmp_in = (vin >= dac_trial);

  sar_seq uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sw_start(sw_start),
    .ext_trig(ext_trig), .chan_sel(chan_sel), .diff_en(diff_en),
    .timing_cfg(timing_cfg), .cmp_in(cmp_in), .thr_level(thr_level),
    .thr_above(thr_above), .dac_trial(dac_trial), .conv_strobe(conv_strobe),
    .busy(busy), .mux_chan(mux_chan), .mux_diff(mux_diff),
    .data_flat(data_flat), .irq(irq)
  );

  function automatic logic [31:0] reg_of(input int ch);
    return data_flat[ch*32 +: 32];
  endfunction

  function automatic logic [31:0] fmt(input logic [15:0] v);
    return {4'h0, v, 12'h000};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic watch(output int blen, output int spos, output logic irqs,
                       output logic dseen);
    blen = 0; spos = -1; dseen = 1'b0;
    for (int g = 0; g < 5000 && busy; g++) begin
      if (conv_strobe && spos < 0) spos = blen;
      if (mux_diff) dseen = 1'b1;
      blen++;
      @(negedge clk);
    end
    irqs = irq;
  endtask

  task automatic run_one(input int ch, input logic d, input logic [15:0] v,
                         output int blen, output int spos, output logic irqs,
                         output logic dseen);
    @(negedge clk);
    vin = v; chan_sel = 3'(ch); diff_en = d; sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    watch(blen, spos, irqs, dseen);
  endtask

  task automatic idle_count(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy) hi++;
    end
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1", "busy after reset", 32'(busy), 0);
    chk(conv_strobe == 1'b0, "R1", "strobe after reset", 32'(conv_strobe), 0);
    chk(irq == 1'b0, "R1", "irq after reset", 32'(irq), 0);
    for (int c = 0; c < 8; c++)
      chk(reg_of(c) == 32'h0, "R1", "register after reset", reg_of(c), 0);
  endtask

  task automatic t_values();
    int bl, sp; logic iq, ds;
    int chs [6] = '{0, 1, 2, 5, 7, 6};
    logic [15:0] vs [6] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h5A5A, 16'h0001, 16'h7FFF};
    mode = 2'b01; timing_cfg = 32'h0014_0028;
    for (int i = 0; i < 6; i++) begin
      run_one(chs[i], 1'b0, vs[i], bl, sp, iq, ds);
      chk(reg_of(chs[i]) == fmt(vs[i]), "R4", "search result/format R5",
          reg_of(chs[i]), fmt(vs[i]));
      if (i == 0) begin
        chk(bl == 38, "R2", "busy length A=20", 32'(bl), 38);
        chk(sp == 22, "R3", "strobe position A=20", 32'(sp), 22);
      end
    end
    chk(reg_of(0) == fmt(16'h0000) && reg_of(1) == fmt(16'hFFFF), "R5",
        "earlier registers kept", reg_of(1), fmt(16'hFFFF));
  endtask

  task automatic t_acq();
    int bl, sp; logic iq, ds;
    mode = 2'b01;
    timing_cfg = 32'h0000_0028;
    run_one(6, 1'b0, 16'h00FF, bl, sp, iq, ds);
    chk(bl == 19, "R2", "busy length A=0", 32'(bl), 19);
    chk(sp == 3, "R3", "strobe position A=0", 32'(sp), 3);
    timing_cfg = 32'h0005_0028;
    run_one(6, 1'b0, 16'hC3A5, bl, sp, iq, ds);
    chk(bl == 23, "R2", "busy length A=5", 32'(bl), 23);
    chk(sp == 7, "R3", "strobe position A=5", 32'(sp), 7);
    chk(reg_of(6) == fmt(16'hC3A5), "R4", "result A=5", reg_of(6), fmt(16'hC3A5));
    timing_cfg = 32'h0014_0028;
  endtask

  task automatic t_diff();
    int bl, sp; logic iq, ds;
    mode = 2'b01;
    run_one(3, 1'b1, 16'h1234, bl, sp, iq, ds);
    chk(reg_of(3) == fmt(16'h1234), "R5", "diff into positive reg", reg_of(3), fmt(16'h1234));
    chk(ds == 1'b1, "R5", "mux_diff during diff conversion", 32'(ds), 1);
    chk(reg_of(2) == fmt(16'h8000), "R5", "neighbour reg unchanged", reg_of(2), fmt(16'h8000));
    chk(reg_of(4) == 32'h0, "R5", "reg4 unchanged", reg_of(4), 0);
  endtask

  task automatic t_single_ignore();
    int bl, sp, hi; logic iq, ds;
    mode = 2'b01;
    @(negedge clk);
    vin = 16'h0F0F; chan_sel = 3'd7; diff_en = 1'b0; sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    repeat (5) @(negedge clk);
    sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    watch(bl, sp, iq, ds);
    idle_count(40, hi);
    chk(hi == 0, "R6", "start during busy ignored", 32'(hi), 0);
    chk(reg_of(7) == fmt(16'h0F0F), "R6", "single result", reg_of(7), fmt(16'h0F0F));
    mode = 2'b00;
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    idle_count(40, hi);
    chk(hi == 0, "R6", "start in off mode ignored", 32'(hi), 0);
  endtask

  task automatic t_thresh();
    int bl, sp; logic iq, ds;
    mode = 2'b01; thr_level = 16'h4000; thr_above = 1'b1;
    run_one(4, 1'b0, 16'h4001, bl, sp, iq, ds);
    chk(iq == 1'b1, "R10", "above threshold", 32'(iq), 1);
    run_one(4, 1'b0, 16'h4000, bl, sp, iq, ds);
    chk(iq == 1'b0, "R10", "equal threshold", 32'(iq), 0);
    run_one(5, 1'b0, 16'hF000, bl, sp, iq, ds);
    chk(iq == 1'b0, "R10", "other channel", 32'(iq), 0);
    thr_above = 1'b0;
    run_one(4, 1'b0, 16'h3FFF, bl, sp, iq, ds);
    chk(iq == 1'b1, "R10", "below threshold", 32'(iq), 1);
    run_one(4, 1'b0, 16'h9000, bl, sp, iq, ds);
    chk(iq == 1'b0, "R10", "not below", 32'(iq), 0);
  endtask

  task automatic t_ext();
    int bl, sp, hi; logic iq, ds;
    mode = 2'b11; ext_trig = 1'b0;
    @(negedge clk);
    vin = 16'hBEEF; chan_sel = 3'd1; ext_trig = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R7", "edge starts conversion", 32'(busy), 1);
    ext_trig = 1'b0;
    @(negedge clk); ext_trig = 1'b1;
    watch(bl, sp, iq, ds);
    chk(reg_of(1) == fmt(16'hBEEF), "R7", "external result", reg_of(1), fmt(16'hBEEF));
    idle_count(40, hi);
    chk(hi == 0, "R7", "busy edge and held level ignored", 32'(hi), 0);
    ext_trig = 1'b0;
    @(negedge clk); vin = 16'h0AB0; ext_trig = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R7", "second edge starts", 32'(busy), 1);
    watch(bl, sp, iq, ds);
    chk(reg_of(1) == fmt(16'h0AB0), "R7", "second result", reg_of(1), fmt(16'h0AB0));
    ext_trig = 1'b0;
    mode = 2'b00;
  endtask

  task automatic t_cont(input logic [31:0] cfg, input int exp_sp, input string req);
    int t [3]; int n, hi;
    mode = 2'b00; timing_cfg = cfg; vin = 16'h2468; chan_sel = 3'd0;
    @(negedge clk);
    mode = 2'b10;
    n = 0;
    for (int g = 0; g < 1000 && n < 3; g++) begin
      @(negedge clk);
      if (conv_strobe) begin t[n] = cyc; n++; end
    end
    mode = 2'b00;
    chk(n == 3 && (t[2] - t[1]) == exp_sp, req, "continuous strobe spacing",
        32'(t[2] - t[1]), 32'(exp_sp));
    repeat (80) @(negedge clk);
    idle_count(10, hi);
    chk(hi == 0 && reg_of(0) == fmt(16'h2468), req, "stops and stores",
        reg_of(0), fmt(16'h2468));
  endtask

  initial begin
    #(8 * 100000);
    errs++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'b00; sw_start = 1'b0; ext_trig = 1'b0;
    chan_sel = 3'd0; diff_en = 1'b0; timing_cfg = 32'h0014_0028;
    thr_level = 16'hFFFF; thr_above = 1'b1; vin = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_values();
    t_acq();
    t_diff();
    t_single_ignore();
    t_thresh();
    t_ext();
    t_cont(32'h0014_0028, 40, "R8");
    t_cont(32'h0014_0005, 38, "R9");
    t_cont(32'h0004_003C, 60, "R8");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule